// File: doc/BRIEF.md
# ADC Channel-List Sequencer with Averaging

This block is the control engine in front of a successive-approximation converter. Software loads a list of up to eight analog channel numbers and, for each channel, a reduction mode and a sample count. A start request walks the list from its first entry. For each entry the engine requests one or more conversions over a start/done handshake and reduces them to a single value. The value is either passed through, the mean, or the median of the samples. The engine then pushes that value, tagged with its channel number, on a one-cycle result strobe.

Between conversions that belong to the same entry, the engine waits a programmable number of ticks. The tick comes from one of four time-base strobes. Three busy flags report activity: the run as a whole, the reduction step, and the inter-sample wait. A run ends after the last entry in one-shot mode. In continuous mode the list repeats. A stop request lets the current entry complete, and the engine then returns to idle. A narrow mode keeps only the low bits of each converter word.

Top module: `adc_list_seq`

## Requirements
- R1: After reset all three busy flags are clear, `idle` is high, and neither `conv_start` nor `res_valid` is asserted.
- R2: A write to address 0 with bit 2 (start) set is accepted only when the engine is idle and bit 0 (enable) is set in the same write. Once accepted, busy bit 0 (run) is high on the next clock. A start without enable changes nothing.
- R3: The list word at address 1 holds entry n in bits 3n+2..3n, and bits 26..24 hold the last index. A run produces one result per entry, from entry 0 up to the last index, in order, with `res_chan` equal to that entry's channel number.
- R4: The word at address 2 holds the mode of channel c in bits 16+2c+1..16+2c and the count code of channel c in bits 2c+1..2c. Count codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 samples. Mode 0 (and the unused mode 3) takes exactly one conversion and passes it through, whatever the count code.
- R5: Mode 1 returns the sum of the 2^k samples shifted right by k.
- R6: Mode 2 returns the median of the samples. For an even count this is the lower of the two middle values.
- R7: Between two conversions of the same entry the engine waits count+1 ticks, where count is bits 7..0 of the word at address 3. Busy bit 2 (delay) is high for exactly that wait, and no conversion is requested during it.
- R8: Bits 9..8 of the word at address 3 select which bit of `tick_src` advances the delay. Strobes on the other bits have no effect.
- R9: When bit 4 of the control word is set, each converter word is cut to its low NW bits before it is reduced.
- R10: With bit 1 (continuous) clear the engine goes idle after the last entry. With it set, the engine wraps to entry 0.
- R11: Bit 3 (stop) of a control write lets the entry in progress finish and push its result, and the engine then goes idle. A stop while idle has no effect.
- R12: Busy bit 1 (reduce) is high for exactly one cycle per entry, and `res_valid` pulses on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 control, 1 list, 2 averaging, 3 delay |
| cfg_wdata | input | 32 | Register write data |
| tick_src | input | 4 | Four candidate time-base strobes |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel for the requested conversion |
| conv_done | input | 1 | Converter result is valid |
| conv_data | input | DW | Converter result |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 3 | Channel tag of the result |
| res_data | output | DW | Reduced result |
| busy | output | 3 | Bit 2 delay, bit 1 reduce, bit 0 run |
| idle | output | 1 | High when no busy flag is set |

## Verification
The bench builds the block with its defaults: a 12-bit converter word, a 10-bit narrow width and an 8-bit delay count. The two-bit gap between word and narrow width lets a masked sample differ from an unmasked one, so the narrow mode can be seen at the result. The 8-bit delay count allows short, exactly countable waits. Eight-sample median and mean runs reach the deepest ranking and the widest sum the buffer holds.

// File: rtl/adc_list_seq.sv
module adc_list_seq #(
  parameter int DW   = 12,
  parameter int NW   = 10,
  parameter int DLYW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic [3:0]    tick_src,
  output logic          conv_start,
  output logic [2:0]    conv_chan,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  output logic          res_valid,
  output logic [2:0]    res_chan,
  output logic [DW-1:0] res_data,
  output logic [2:0]    busy,
  output logic          idle
);
  localparam int NBUF = 8;
  localparam int SW   = DW + 3;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CONV, S_WAIT, S_DLY, S_RED} st_t;

  st_t             st_q;
  logic            cont_q, nar_q, stop_pend_q;
  logic [2:0]      maxidx_q, idx_q, chan_q;
  logic [23:0]     list_q;
  logic [31:0]     avg_q;
  logic [DLYW-1:0] dly_q, dcnt_q;
  logic [1:0]      tsel_q, mode_q, code_q;
  logic [3:0]      n_q;
  logic [SW-1:0]   sum_q;
  logic [DW-1:0]   buf_q [NBUF];
  logic [3:0]      rank [NBUF];

  logic            ctl_wr, start_acc, stop_req, tick, multi, last_smp;
  logic [2:0]      lchan;
  logic [3:0]      need;
  logic [DW-1:0]   smp, med, red;

  assign ctl_wr    = cfg_we && cfg_addr == 2'd0;
  assign start_acc = ctl_wr && cfg_wdata[2] && cfg_wdata[0] && st_q == S_IDLE;
  assign stop_req  = ctl_wr && cfg_wdata[3];
  assign tick      = tick_src[tsel_q];
  assign lchan     = list_q[3*idx_q +: 3];
  assign multi     = mode_q == 2'd1 || mode_q == 2'd2;
  assign need      = multi ? (4'd1 << code_q) : 4'd1;
  assign last_smp  = (n_q + 4'd1) == need;
  assign smp       = nar_q ? {{(DW-NW){1'b0}}, conv_data[NW-1:0]} : conv_data;

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      rank[i] = '0;
      for (int j = 0; j < NBUF; j++)
        if (j != i && j < int'(need) &&
            (buf_q[j] < buf_q[i] || (buf_q[j] == buf_q[i] && j < i)))
          rank[i] = rank[i] + 4'd1;
    end
    med = buf_q[0];
    for (int i = 0; i < NBUF; i++)
      if (i < int'(need) && rank[i] == ((need - 4'd1) >> 1))
        med = buf_q[i];
  end

  always_comb begin
    case (mode_q)
      2'd1:    red = DW'(sum_q >> code_q);
      2'd2:    red = med;
      default: red = buf_q[0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      cont_q      <= 1'b0;
      nar_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      maxidx_q    <= '0;
      idx_q       <= '0;
      chan_q      <= '0;
      list_q      <= '0;
      avg_q       <= '0;
      dly_q       <= '0;
      dcnt_q      <= '0;
      tsel_q      <= '0;
      mode_q      <= '0;
      code_q      <= '0;
      n_q         <= '0;
      sum_q       <= '0;
      res_valid   <= 1'b0;
      res_chan    <= '0;
      res_data    <= '0;
      for (int i = 0; i < NBUF; i++) buf_q[i] <= '0;
    end else begin
      res_valid <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: begin
            cont_q <= cfg_wdata[1];
            nar_q  <= cfg_wdata[4];
          end
          2'd1: begin
            list_q   <= cfg_wdata[23:0];
            maxidx_q <= cfg_wdata[26:24];
          end
          2'd2:    avg_q <= cfg_wdata;
          default: begin
            dly_q  <= cfg_wdata[DLYW-1:0];
            tsel_q <= cfg_wdata[DLYW +: 2];
          end
        endcase
      end
      if (stop_req && st_q != S_IDLE) stop_pend_q <= 1'b1;

      case (st_q)
        S_IDLE: if (start_acc) begin
          idx_q       <= '0;
          stop_pend_q <= 1'b0;
          st_q        <= S_LOAD;
        end
        S_LOAD: begin
          chan_q <= lchan;
          mode_q <= avg_q[16 + 2*lchan +: 2];
          code_q <= avg_q[2*lchan +: 2];
          n_q    <= '0;
          sum_q  <= '0;
          st_q   <= S_CONV;
        end
        S_CONV: st_q <= S_WAIT;
        S_WAIT: if (conv_done) begin
          buf_q[n_q[2:0]] <= smp;
          sum_q           <= sum_q + SW'(smp);
          n_q             <= n_q + 4'd1;
          if (last_smp) st_q <= S_RED;
          else begin
            dcnt_q <= dly_q;
            st_q   <= S_DLY;
          end
        end
        S_DLY: if (tick) begin
          if (dcnt_q == '0) st_q <= S_CONV;
          else dcnt_q <= dcnt_q - 1'b1;
        end
        S_RED: begin
          res_valid <= 1'b1;
          res_chan  <= chan_q;
          res_data  <= red;
          if (stop_pend_q || stop_req) begin
            st_q        <= S_IDLE;
            stop_pend_q <= 1'b0;
          end else if (idx_q == maxidx_q) begin
            if (cont_q) begin
              idx_q <= '0;
              st_q  <= S_LOAD;
            end else st_q <= S_IDLE;
          end else begin
            idx_q <= idx_q + 3'd1;
            st_q  <= S_LOAD;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign conv_start = st_q == S_CONV;
  assign conv_chan  = chan_q;
  assign busy       = {st_q == S_DLY, st_q == S_RED, st_q != S_IDLE};
  assign idle       = busy == 3'b000;
endmodule

// File: rtl/adc_list_seq_chk.sv
module adc_list_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [1:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        conv_start,
  input logic        res_valid,
  input logic [2:0]  busy,
  input logic        idle
);
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd0 && cfg_wdata[2] && cfg_wdata[0] && idle) |=> busy[0]);

  assert_conv_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy[0]);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !conv_start);

  assert_no_conv_in_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy[2] |-> !conv_start);

  assert_reduce_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy[1] |=> !busy[1]);

  assert_result_after_reduce_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy[1] |=> res_valid);

  assert_conv_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
endmodule

bind adc_list_seq adc_list_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .conv_start(conv_start), .res_valid(res_valid),
  .busy(busy), .idle(idle)
);

// File: tb/adc_list_seq_tb.sv
`timescale 1ns/1ps
module adc_list_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [3:0]  tick_src;
  logic        conv_start, conv_done;
  logic [2:0]  conv_chan;
  logic [11:0] conv_data;
  logic        res_valid;
  logic [2:0]  res_chan;
  logic [11:0] res_data;
  logic [2:0]  busy;
  logic        idle;

  int nchk = 0, nfail = 0, kconv = 0;
  int rq_ch[$];
  int rq_d[$];

  // {narrow, code[1:0], mode[1:0], chan[2:0]}
  localparam logic [7:0] VEC [10] = '{
    {1'b0, 2'd3, 2'd0, 3'd3}, {1'b0, 2'd0, 2'd1, 3'd5},
    {1'b0, 2'd1, 2'd1, 3'd1}, {1'b0, 2'd2, 2'd1, 3'd2},
    {1'b0, 2'd3, 2'd1, 3'd7}, {1'b0, 2'd1, 2'd2, 3'd0},
    {1'b0, 2'd2, 2'd2, 3'd4}, {1'b0, 2'd3, 2'd2, 3'd6},
    {1'b1, 2'd3, 2'd1, 3'd2}, {1'b0, 2'd2, 2'd3, 3'd6}
  };

  always #4 clk = ~clk;

  adc_list_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick_src(tick_src), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
    .busy(busy), .idle(idle)
  );

  function automatic int smpfn(int ch, int k);
    return ((ch*797 + k*1237 + k*k*311) ^ 'hA5C) & 'hFFF;
  endfunction

  function automatic int expv(int md, int cd, int nr, int ch, int kb);
    int n, s, t;
    int a[8];
    n = (md == 1 || md == 2) ? (1 << cd) : 1;
    s = 0;
    for (int i = 0; i < n; i++) begin
      a[i] = smpfn(ch, kb + i);
      if (nr != 0) a[i] = a[i] & 'h3FF;
      s += a[i];
    end
    if (md == 1) return s >> cd;
    if (md == 2) begin
      for (int p = 0; p < n; p++)
        for (int q = 0; q + 1 < n - p; q++)
          if (a[q] > a[q+1]) begin t = a[q]; a[q] = a[q+1]; a[q+1] = t; end
      return a[(n-1)/2];
    end
    return a[0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && !idle; i++) @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic clr_q();
    rq_ch.delete();
    rq_d.delete();
  endtask

  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      int ch;
      @(negedge clk);
      if (conv_start) begin
        ch = int'(conv_chan);
        @(negedge clk);
        conv_data = 12'(smpfn(ch, kconv));
        kconv++;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (res_valid) begin
        rq_ch.push_back(int'(res_chan));
        rq_d.push_back(int'(res_data));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int kb, cnt, b1, rv;
    logic [31:0] aw;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; tick_src = 4'b0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 3'b000 && idle && !conv_start && !res_valid, "R1",
        int'({busy, idle, conv_start, res_valid}), 4);

    wr(2'd3, 32'h0);
    for (int v = 0; v < 10; v++) begin
      int ch, md, cd, nr;
      ch = int'(VEC[v][2:0]); md = int'(VEC[v][4:3]);
      cd = int'(VEC[v][6:5]); nr = int'(VEC[v][7]);
      aw = 32'hFFFF_FFFF;
      aw[16 + 2*ch +: 2] = 2'(md);
      aw[2*ch +: 2] = 2'(cd);
      wr(2'd2, aw);
      wr(2'd1, 32'h00FF_FFF8 | 32'(ch));
      clr_q();
      kb = kconv;
      wr(2'd0, 32'h5 | (32'(nr) << 4));
      wait_idle();
      chk(rq_d.size() == 1 && rq_ch[0] == ch, "R3 tag", rq_ch.size() > 0 ? rq_ch[0] : -1, ch);
      if (rq_d.size() == 1) begin
        if (nr != 0) chk(rq_d[0] == expv(md, cd, nr, ch, kb), "R9", rq_d[0], expv(md, cd, nr, ch, kb));
        else if (md == 1) chk(rq_d[0] == expv(md, cd, nr, ch, kb), "R5", rq_d[0], expv(md, cd, nr, ch, kb));
        else if (md == 2) chk(rq_d[0] == expv(md, cd, nr, ch, kb), "R6", rq_d[0], expv(md, cd, nr, ch, kb));
        else chk(rq_d[0] == expv(md, cd, nr, ch, kb), "R4", rq_d[0], expv(md, cd, nr, ch, kb));
      end
    end

    // R2: start rejected without enable
    wr(2'd1, 32'h0000_0001);
    wr(2'd2, 32'h0);
    clr_q();
    kb = kconv;
    wr(2'd0, 32'h4);
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (busy != 3'b000) cnt++;
    end
    chk(cnt == 0 && kconv == kb && rq_d.size() == 0, "R2 no enable", cnt + kconv - kb, 0);

    // R2: run busy on the clock after an accepted start
    wr(2'd0, 32'h5);
    chk(busy[0] == 1'b1, "R2 busy", int'(busy[0]), 1);
    wait_idle();

    // R3, R10: three-entry one-shot list
    wr(2'd1, 32'h0200_0000 | (32'd3 << 9) | (32'd4 << 6) | (32'd1 << 3) | 32'd6);
    clr_q();
    kb = kconv;
    wr(2'd0, 32'h5);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(rq_ch.size() == 3, "R10 one-shot count", rq_ch.size(), 3);
    if (rq_ch.size() == 3) begin
      chk(rq_ch[0] == 6 && rq_ch[1] == 1 && rq_ch[2] == 4, "R3 order",
          rq_ch[0]*100 + rq_ch[1]*10 + rq_ch[2], 614);
      chk(rq_d[1] == smpfn(1, kb + 1) && rq_d[2] == smpfn(4, kb + 2), "R3 data",
          rq_d[2], smpfn(4, kb + 2));
    end

    // R10, R11: continuous wrap, then stop
    wr(2'd1, 32'h0100_0000 | (32'd5 << 3) | 32'd2);
    clr_q();
    wr(2'd0, 32'h7);
    for (int i = 0; i < 3000 && rq_ch.size() < 5; i++) begin
      @(negedge clk);
      #1;
    end
    wr(2'd0, 32'h8);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(rq_ch.size() == 6, "R11 stop finishes entry", rq_ch.size(), 6);
    if (rq_ch.size() == 6)
      chk(rq_ch[2] == 2 && rq_ch[3] == 5 && rq_ch[5] == 5, "R10 wrap",
          rq_ch[2]*100 + rq_ch[3]*10 + rq_ch[5], 255);
    wr(2'd0, 32'h8);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!idle) cnt++;
    end
    chk(cnt == 0, "R11 idle stop", cnt, 0);

    // R7, R12: delay count and reduce flag
    wr(2'd1, 32'h0000_0001);
    wr(2'd2, 32'h0001_0000 << 2 | 32'h4);
    wr(2'd3, 32'h0000_0005);
    clr_q();
    kb = kconv;
    wr(2'd0, 32'h5);
    cnt = 0; b1 = 0; rv = 0;
    for (int i = 0; i < 3000 && !idle; i++) begin
      if (busy[2]) cnt++;
      if (busy[1]) b1++;
      @(negedge clk);
      if (res_valid && busy[0] == 1'b0) rv++;
    end
    chk(cnt == 6, "R7 delay", cnt, 6);
    chk(b1 == 1 && rv == 1, "R12 reduce", b1*10 + rv, 11);
    @(negedge clk);
    chk(rq_d.size() == 1 && rq_d[0] == expv(1, 1, 0, 1, kb), "R5 delayed",
        rq_d.size() > 0 ? rq_d[0] : -1, expv(1, 1, 0, 1, kb));

    // R8: tick selector
    wr(2'd3, 32'h0000_0102);
    tick_src = 4'b0001;
    clr_q();
    wr(2'd0, 32'h5);
    repeat (60) @(negedge clk);
    chk(busy[2] == 1'b1 && rq_d.size() == 0, "R8 hold", int'(busy[2]), 1);
    tick_src = 4'b0011;
    wait_idle();
    repeat (4) @(negedge clk);
    chk(rq_d.size() == 1, "R8 release", rq_d.size(), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule